// File: doc/BRIEF.md
# Radio Module Sleep and Wake Sequencer

This block decides when a serial-controlled radio module goes to sleep and how it comes back. A host write of 1 to the idle bit starts entry. The block offers an acknowledge byte to the external UART transmitter and waits until that byte is taken. It then waits for any radio transmission in progress to finish, and only then enters sleep. During sleep the functional output pins are forced to per-pin sleep levels: some hold their last value, some are driven low and some are driven high. The command-response line also goes low.

In sleep, a qualified rising edge on the command-data input wakes the module. Activity on any other wake-capable input wakes it for a single cycle only, and it then falls back asleep with nothing else changed. A full wake clears the idle bit and optionally sends a wake acknowledge byte. It then passes through a one-cycle resume state and raises the command-response line.

Two inputs override all of this. A sustained low on the power-down input puts the block in its off state whatever the idle bit says, and a rising edge on that input wakes it again. A low level on the reset input forces a restart. If the volatile state is flagged as corrupted when a wake happens, the block also restarts instead of resuming. Bytes leave through a valid/ready handshake. Entry into sleep does not depend on bytes still waiting in the incoming serial buffer.

Top module: `slpwk_ctrl`

## Requirements
- R1: After reset the block is active: idle_o=0, cresp_o=1, sleep_o=0, off_o=0, byte_valid_o=0, and pin_o equals pin_act_i.
- R2: In the active state, a write with idle_wr_i=1 and idle_wdata_i=1 sets idle_o=1. The block then offers byte 0x06 with byte_valid_o=1 and keeps the byte steady until byte_ready_i accepts it.
- R3: After the acknowledge byte is accepted, the block stays awake for as long as tx_busy_i=1. It enters sleep (sleep_o=1) on the first cycle that tx_busy_i is 0.
- R4: In sleep and off, pin_o is forced to its sleep levels, and cresp_o=0 during sleep. The per-pin levels are: pin 0 (status expansion) and pin 6 (extra output) hold their last active value. Pins 1 (LNA enable), 2 (PA enable) and 5 (mode indicator) are driven 0. Pins 3 (serial transmit) and 4 (clear to send) are driven 1.
- R5: Both cmd_in_i and pdn_i are synchronised. In sleep, a rising edge on cmd_in_i wakes the block only if the input was low for at least MIN_LOW cycles; a shorter low pulse leaves the block asleep.
- R6: In sleep, other_wake_i=1 drops sleep_o for exactly one cycle and then returns to sleep. During this it keeps idle_o=1 and sends no byte.
- R7: A full wake clears idle_o. If wake_ack_en_i=1, byte 0x06 is sent before cresp_o rises; if wake_ack_en_i=0, no byte is sent. cresp_o then goes to 1 and normal operation resumes.
- R8: When pdn_i has been low for at least MIN_LOW cycles, the block enters off (off_o=1) from any state, with pins at their sleep levels. A shorter low is ignored. A rising edge on pdn_i runs the wake sequence of R7.
- R9: When resetn_i=0 outside the off state, the block pulses restart_o for one cycle and returns to the active state with idle_o=0 and no byte sent.
- R10: If corrupt_i=1 at the moment of a wake, the block pulses restart_o instead of sending the wake acknowledge byte, and then becomes active with idle_o=0.
- R11: A write of 0 to the idle bit, and a qualified rising edge on cmd_in_i while active, leave the block active with no byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_wr_i | input | 1 | Host write strobe for the idle bit |
| idle_wdata_i | input | 1 | Value written to the idle bit |
| wake_ack_en_i | input | 1 | Configuration: send a byte on wake |
| tx_busy_i | input | 1 | Radio transmission in progress |
| pdn_i | input | 1 | Power-down input, low means off |
| cmd_in_i | input | 1 | Command-data input, wake edge source |
| other_wake_i | input | 1 | Activity on any other wake-capable input |
| resetn_i | input | 1 | Reset input, low forces a restart |
| corrupt_i | input | 1 | Volatile state flagged as corrupted |
| byte_ready_i | input | 1 | UART transmitter accepts the byte |
| byte_valid_o | output | 1 | Byte offered to the UART transmitter |
| byte_o | output | 8 | Byte value |
| idle_o | output | 1 | Current idle bit |
| cresp_o | output | 1 | Command-response line |
| sleep_o | output | 1 | Sleep status |
| off_o | output | 1 | Off status |
| restart_o | output | 1 | One-cycle restart pulse |
| pin_act_i | input | NPIN | Active-mode values of the functional pins |
| pin_o | output | NPIN | Functional pins after sleep forcing |

## Verification
The wake logic is driven with four patterns. A long low pulse on the command input separates a qualified wake from a short low pulse, which must leave the block asleep. A one-cycle pulse on the other-input line separates a brief wake from a full one. Short and long lows on the power-down input show whether the off state is gated by the low-time qualifier. A reset-input pulse and a wake with the corruption flag set show the two restart paths.

Each wake is run both with and without the wake acknowledge enabled, so the byte scoreboard can tell an acknowledged wake from a silent one. Pin values are changed during sleep, which shows whether the held pins keep their value and the driven pins ignore the new input.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE     = 3'd0,
        ST_SEND_ACK   = 3'd1,
        ST_WAIT_TX    = 3'd2,
        ST_SLEEP      = 3'd3,
        ST_BRIEF_WAKE = 3'd4,
        ST_WAKE_ACK   = 3'd5,
        ST_RESUME     = 3'd6,
        ST_OFF        = 3'd7
    } slp_state_e;

    // Byte used both for the entry acknowledge and the wake acknowledge
    localparam logic [7:0] ACK_CODE = 8'h06;

    // Channel indices of the qualified edge inputs
    localparam int unsigned CH_PDN = 0;
    localparam int unsigned CH_CMD = 1;
    localparam int unsigned N_CH   = 2;

    typedef struct packed {
        logic rise_ok;   // rising edge after a long enough low
        logic low_long;  // currently low for at least the minimum time
    } edge_info_t;

    function automatic logic pins_forced(slp_state_e s);
        return (s == ST_SLEEP) || (s == ST_BRIEF_WAKE) || (s == ST_OFF);
    endfunction

endpackage

// File: rtl/slpwk_edge_qual.sv
module slpwk_edge_qual
    import slpwk_pkg::*;
#(
    parameter int unsigned MIN_LOW = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din_i,
    output edge_info_t info_o
);
    localparam int unsigned CW   = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

    logic          s1_q, s2_q, prev_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= 1'b1;
            s2_q      <= 1'b1;
            prev_q    <= 1'b1;
            low_cnt_q <= '0;
        end else begin
            s1_q   <= din_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
            if (!s2_q) begin
                if (low_cnt_q != CMAX) low_cnt_q <= low_cnt_q + 1'b1;
            end else begin
                low_cnt_q <= '0;
            end
        end
    end

    always_comb begin
        info_o.rise_ok  = !prev_q && s2_q && (low_cnt_q == CMAX);
        info_o.low_long = !s2_q && (low_cnt_q == CMAX);
    end

endmodule

// File: rtl/slpwk_pin_mux.sv
module slpwk_pin_mux #(
    parameter int unsigned      NPIN      = 7,
    parameter logic [NPIN-1:0]  HOLD_MASK = 7'b1000001,
    parameter logic [NPIN-1:0]  HIGH_MASK = 7'b0011000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            force_i,
    input  logic [NPIN-1:0] act_i,
    output logic [NPIN-1:0] pin_o
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (HOLD_MASK[i]) begin : g_hold
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst)          held_q <= 1'b0;
                else if (!force_i) held_q <= act_i[i];
            end
            assign pin_o[i] = force_i ? held_q : act_i[i];
        end else begin : g_fixed
            assign pin_o[i] = force_i ? HIGH_MASK[i] : act_i[i];
        end
    end

endmodule

// File: rtl/slpwk_fsm.sv
module slpwk_fsm
    import slpwk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_wr_i,
    input  logic       idle_wdata_i,
    input  logic       wake_ack_en_i,
    input  logic       tx_busy_i,
    input  logic       resetn_i,
    input  logic       other_wake_i,
    input  logic       corrupt_i,
    input  logic       cmd_rise_i,
    input  logic       pdn_rise_i,
    input  logic       pdn_off_i,
    input  logic       byte_ready_i,
    output slp_state_e state_o,
    output logic       idle_o,
    output logic       restart_o,
    output logic       byte_valid_o,
    output logic [7:0] byte_o
);
    slp_state_e st_q, st_n;
    logic       idle_q, idle_n;
    logic       restart_q, restart_n;
    logic       wake_now;

    always_comb begin
        st_n      = st_q;
        idle_n    = idle_q;
        restart_n = 1'b0;
        wake_now  = 1'b0;

        unique case (st_q)
            ST_ACTIVE:     if (idle_wr_i && idle_wdata_i) begin
                               st_n   = ST_SEND_ACK;
                               idle_n = 1'b1;
                           end
            ST_SEND_ACK:   if (byte_ready_i) st_n = ST_WAIT_TX;
            ST_WAIT_TX:    if (!tx_busy_i)   st_n = ST_SLEEP;
            ST_SLEEP:      if (cmd_rise_i)   wake_now = 1'b1;
                           else if (other_wake_i) st_n = ST_BRIEF_WAKE;
            ST_BRIEF_WAKE: st_n = ST_SLEEP;
            ST_WAKE_ACK:   if (byte_ready_i) st_n = ST_RESUME;
            ST_RESUME:     st_n = ST_ACTIVE;
            ST_OFF:        if (pdn_rise_i)   wake_now = 1'b1;
            default:       st_n = ST_ACTIVE;
        endcase

        if (wake_now) begin
            idle_n = 1'b0;
            if (corrupt_i) begin
                st_n      = ST_RESUME;
                restart_n = 1'b1;
            end else begin
                st_n = wake_ack_en_i ? ST_WAKE_ACK : ST_RESUME;
            end
        end

        // Overrides: power-down first, then the reset input
        if (pdn_off_i && st_q != ST_OFF) begin
            st_n      = ST_OFF;
            restart_n = 1'b0;
        end else if (!resetn_i && st_q != ST_OFF) begin
            st_n      = ST_ACTIVE;
            idle_n    = 1'b0;
            restart_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_ACTIVE;
            idle_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            st_q      <= st_n;
            idle_q    <= idle_n;
            restart_q <= restart_n;
        end
    end

    assign state_o      = st_q;
    assign idle_o       = idle_q;
    assign restart_o    = restart_q;
    assign byte_valid_o = (st_q == ST_SEND_ACK) || (st_q == ST_WAKE_ACK);
    assign byte_o       = ACK_CODE;

endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
    import slpwk_pkg::*;
#(
    parameter int unsigned     NPIN      = 7,
    parameter logic [NPIN-1:0] HOLD_MASK = 7'b1000001,
    parameter logic [NPIN-1:0] HIGH_MASK = 7'b0011000,
    parameter int unsigned     MIN_LOW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            idle_wr_i,
    input  logic            idle_wdata_i,
    input  logic            wake_ack_en_i,
    input  logic            tx_busy_i,
    input  logic            pdn_i,
    input  logic            cmd_in_i,
    input  logic            other_wake_i,
    input  logic            resetn_i,
    input  logic            corrupt_i,
    input  logic            byte_ready_i,
    output logic            byte_valid_o,
    output logic [7:0]      byte_o,
    output logic            idle_o,
    output logic            cresp_o,
    output logic            sleep_o,
    output logic            off_o,
    output logic            restart_o,
    input  logic [NPIN-1:0] pin_act_i,
    output logic [NPIN-1:0] pin_o
);
    logic [N_CH-1:0] raw_in;
    edge_info_t      info [N_CH];
    slp_state_e      state;

    assign raw_in[CH_PDN] = pdn_i;
    assign raw_in[CH_CMD] = cmd_in_i;

    for (genvar c = 0; c < N_CH; c++) begin : g_in
        slpwk_edge_qual #(.MIN_LOW(MIN_LOW)) u_qual (
            .clk    (clk),
            .rst    (rst),
            .din_i  (raw_in[c]),
            .info_o (info[c])
        );
    end

    slpwk_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .idle_wr_i     (idle_wr_i),
        .idle_wdata_i  (idle_wdata_i),
        .wake_ack_en_i (wake_ack_en_i),
        .tx_busy_i     (tx_busy_i),
        .resetn_i      (resetn_i),
        .other_wake_i  (other_wake_i),
        .corrupt_i     (corrupt_i),
        .cmd_rise_i    (info[CH_CMD].rise_ok),
        .pdn_rise_i    (info[CH_PDN].rise_ok),
        .pdn_off_i     (info[CH_PDN].low_long),
        .byte_ready_i  (byte_ready_i),
        .state_o       (state),
        .idle_o        (idle_o),
        .restart_o     (restart_o),
        .byte_valid_o  (byte_valid_o),
        .byte_o        (byte_o)
    );

    slpwk_pin_mux #(
        .NPIN      (NPIN),
        .HOLD_MASK (HOLD_MASK),
        .HIGH_MASK (HIGH_MASK)
    ) u_pins (
        .clk     (clk),
        .rst     (rst),
        .force_i (pins_forced(state)),
        .act_i   (pin_act_i),
        .pin_o   (pin_o)
    );

    assign cresp_o = (state == ST_ACTIVE);
    assign sleep_o = (state == ST_SLEEP);
    assign off_o   = (state == ST_OFF);

endmodule

// File: rtl/slpwk_ctrl_chk.sv
module slpwk_ctrl_chk #(
    parameter int unsigned     NPIN      = 7,
    parameter logic [NPIN-1:0] HOLD_MASK = 7'b1000001,
    parameter logic [NPIN-1:0] HIGH_MASK = 7'b0011000
) (
    input logic            clk,
    input logic            rst,
    input logic            byte_valid_o,
    input logic            byte_ready_i,
    input logic [7:0]      byte_o,
    input logic            idle_o,
    input logic            cresp_o,
    input logic            sleep_o,
    input logic            off_o,
    input logic            restart_o,
    input logic [NPIN-1:0] pin_o
);
    // R2
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o && !byte_ready_i |=>
            (byte_valid_o && $stable(byte_o)) || off_o || restart_o);

    // R3
    sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> idle_o);

    // R4
    sleep_levels_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_o |-> (((pin_o & ~HOLD_MASK) == HIGH_MASK) && !cresp_o && !byte_valid_o));

    // R4
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_o && $past(sleep_o) |-> ((pin_o & HOLD_MASK) == ($past(pin_o) & HOLD_MASK)));

    // R7
    resume_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cresp_o) |-> !idle_o);

    // R9
    restart_idle_chk: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> !idle_o && !byte_valid_o);

endmodule

bind slpwk_ctrl slpwk_ctrl_chk #(
    .NPIN      (NPIN),
    .HOLD_MASK (HOLD_MASK),
    .HIGH_MASK (HIGH_MASK)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (byte_ready_i),
    .byte_o       (byte_o),
    .idle_o       (idle_o),
    .cresp_o      (cresp_o),
    .sleep_o      (sleep_o),
    .off_o        (off_o),
    .restart_o    (restart_o),
    .pin_o        (pin_o)
);

// File: tb/slpwk_ctrl_tb_top.sv
module slpwk_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN       = 7;
    localparam logic [NPIN-1:0] HOLD_M = 7'b1000001;
    localparam logic [NPIN-1:0] HIGH_M = 7'b0011000;
    localparam int WDOG       = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic idle_wr_i = 0, idle_wdata_i = 0, wake_ack_en_i = 0, tx_busy_i = 0;
    logic pdn_i = 1, cmd_in_i = 1, other_wake_i = 0, resetn_i = 1, corrupt_i = 0;
    logic byte_ready_i = 0;
    logic byte_valid_o, idle_o, cresp_o, sleep_o, off_o, restart_o;
    logic [7:0] byte_o;
    logic [NPIN-1:0] pin_act_i = '0;
    logic [NPIN-1:0] pin_o;

    int n_cmp = 0, n_bad = 0, n_restart = 0, wait_cnt = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slpwk_ctrl dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Responder and scoreboard monitor: accept after two wait cycles
    always @(negedge clk) begin
        if (!rst && byte_valid_o) begin
            if (wait_cnt == 2) begin
                byte_ready_i <= 1'b1;
                wait_cnt = 0;
                if (exp_q.size() == 0)
                    chk(0, "R7 unexpected byte", {24'd0, byte_o}, 32'hFFFF);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_o == e, "R2/R7 byte value", {24'd0, byte_o}, {24'd0, e});
                end
            end else begin
                byte_ready_i <= 1'b0;
                wait_cnt++;
            end
        end else begin
            byte_ready_i <= 1'b0;
            wait_cnt = 0;
        end
        if (!rst && restart_o) n_restart++;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep();
        exp_q.push_back(8'h06);
        tx_busy_i = 1;
        idle_wr_i = 1; idle_wdata_i = 1;
        cyc(1);
        idle_wr_i = 0; idle_wdata_i = 0;
        chk(idle_o == 1, "R2 idle set", idle_o, 1);
        cyc(10);
        chk(sleep_o == 0, "R3 awake while busy", sleep_o, 0);
        chk(exp_q.size() == 0, "R2 ack byte sent", exp_q.size(), 0);
        tx_busy_i = 0;
        cyc(2);
        chk(sleep_o == 1, "R3 sleep after tx", sleep_o, 1);
    endtask

    task automatic cmd_pulse(input int low);
        cmd_in_i = 0; cyc(low); cmd_in_i = 1; cyc(20);
    endtask

    initial begin
        logic [NPIN-1:0] act0;
        int r0;
        cyc(3);
        rst = 0;
        act0 = 7'b0100101;
        pin_act_i = act0;
        cyc(1);
        // R1 reset state
        chk(idle_o == 0 && cresp_o == 1 && sleep_o == 0 && off_o == 0 && byte_valid_o == 0,
            "R1 reset state", {idle_o, cresp_o, sleep_o, off_o, byte_valid_o}, 5'b01000);
        chk(pin_o == act0, "R1 pin pass", pin_o, act0);

        // R11 write 0 and cmd edge while active
        idle_wr_i = 1; idle_wdata_i = 0; cyc(1); idle_wr_i = 0;
        cyc(2);
        chk(idle_o == 0 && cresp_o == 1, "R11 write zero", idle_o, 0);
        cmd_pulse(10);
        chk(cresp_o == 1 && sleep_o == 0, "R11 cmd edge active", cresp_o, 1);

        // R3/R4 sleep entry and pin levels
        go_sleep();
        pin_act_i = ~act0;
        cyc(2);
        chk(pin_o == ((act0 & HOLD_M) | HIGH_M), "R4 sleep pins", pin_o, (act0 & HOLD_M) | HIGH_M);
        chk(cresp_o == 0, "R4 cresp low", cresp_o, 0);

        // R5 short pulse does not wake
        cmd_pulse(2);
        chk(sleep_o == 1 && idle_o == 1, "R5 short pulse ignored", sleep_o, 1);

        // R6 brief wake
        other_wake_i = 1; cyc(1); other_wake_i = 0;
        chk(sleep_o == 0 && idle_o == 1 && byte_valid_o == 0, "R6 brief wake", sleep_o, 0);
        cyc(1);
        chk(sleep_o == 1, "R6 back to sleep", sleep_o, 1);
        chk(pin_o == ((act0 & HOLD_M) | HIGH_M), "R4 pins after brief wake", pin_o, (act0 & HOLD_M) | HIGH_M);

        // R5/R7 wake with acknowledge
        wake_ack_en_i = 1;
        exp_q.push_back(8'h06);
        cmd_pulse(10);
        chk(cresp_o == 1 && idle_o == 0 && sleep_o == 0, "R7 wake ack resume", {cresp_o, idle_o}, 2'b10);
        chk(exp_q.size() == 0, "R7 wake byte sent", exp_q.size(), 0);
        chk(pin_o == ~act0, "R7 pins released", pin_o, ~act0);

        // R7 wake without acknowledge
        wake_ack_en_i = 0;
        go_sleep();
        cmd_pulse(10);
        chk(cresp_o == 1 && idle_o == 0, "R7 silent wake", {cresp_o, idle_o}, 2'b10);

        // R8 short pdn glitch ignored, long low enters off
        pdn_i = 0; cyc(2); pdn_i = 1; cyc(10);
        chk(off_o == 0 && cresp_o == 1, "R8 pdn glitch", off_o, 0);
        pdn_i = 0; cyc(12);
        chk(off_o == 1 && cresp_o == 0, "R8 off state", off_o, 1);
        chk(pin_o == ((~act0 & HOLD_M) | HIGH_M), "R8 off pins", pin_o, (~act0 & HOLD_M) | HIGH_M);
        wake_ack_en_i = 1;
        exp_q.push_back(8'h06);
        pdn_i = 1; cyc(20);
        chk(off_o == 0 && cresp_o == 1 && idle_o == 0, "R8 pdn wake", {off_o, cresp_o}, 2'b01);

        // R9 reset input from sleep
        go_sleep();
        r0 = n_restart;
        resetn_i = 0; cyc(1); resetn_i = 1;
        chk(restart_o == 1 && cresp_o == 1 && idle_o == 0, "R9 restart", {restart_o, cresp_o, idle_o}, 3'b110);
        cyc(1);
        chk(restart_o == 0, "R9 single pulse", restart_o, 0);
        cyc(5);
        chk(n_restart == r0 + 1, "R9 pulse count", n_restart - r0, 1);

        // R10 corrupted state at wake
        go_sleep();
        r0 = n_restart;
        corrupt_i = 1;
        cmd_pulse(10);
        corrupt_i = 0;
        chk(n_restart == r0 + 1, "R10 restart on corrupt", n_restart - r0, 1);
        chk(cresp_o == 1 && idle_o == 0, "R10 active after", {cresp_o, idle_o}, 2'b10);

        cyc(5);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule